// File: doc/BRIEF.md
# USB Host Status and Interrupt Register

This block holds the five sticky status flags of a USB 2.0 host controller and turns them into a single interrupt request. The rest of the controller feeds it with one-cycle event pulses: a transaction completed, whether that transaction carried interrupt-on-complete, whether it ended in error, whether a short packet was received, and whether a memory read by the controller came back unsuccessful. It also sees bit 13 of the microframe counter and the live change, force-resume and owner bits of every root port, and finds the rising edges itself.

Software reaches three small registers over a plain word bus: command, status and interrupt enable. Status flags are cleared by writing 1 to them. A failed memory read does more than raise a flag: it also drops the run/stop command bit so the schedule stops at once. The interrupt output is a registered level that stays high while any enabled flag is set.

Top module: `usb_hc_status_intr`

## Requirements
- R1: While reset is high and on the first cycle after it, status, interrupt enable, run/stop and irq are all 0.
- R2: Status bit 0 (USB interrupt) is set one clock after a cycle with the completion pulse together with the interrupt-on-complete flag, or a cycle with the short-packet pulse.
- R3: Status bit 1 (error interrupt) is set one clock after a completion pulse with the error flag; when the interrupt-on-complete flag is also high, bits 1 and 0 are both set.
- R4: A failed memory read sets status bit 4 (host system error) and clears run/stop (command register bit 0) on the same clock, even when software writes 1 to run/stop in that cycle.
- R5: Status bit 3 (frame list rollover) is set one clock after each change of the frame counter bit 13 input, in either direction.
- R6: Status bit 2 (port change) is set when, on a port whose owner input is 0, any change bit or the force-resume bit rises from 0 to 1; rises on a port with owner 1 and falling edges have no effect.
- R7: Writing a status word clears each bit written as 1; bits written as 0 keep their value.
- R8: When a hardware set and a software clear meet on the same status bit in the same cycle, the bit ends up set.
- R9: irq is high exactly while some status bit and its enable bit (same position, enable register) are both 1; it changes on the same clock edge as the status or enable register.
- R10: A write to the command register loads run/stop from data bit 0, unless a failed memory read occurs in that cycle.
- R11: Register address 0 is command, 1 status, 2 interrupt enable, 3 reads as 0; read data for the address presented appears after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_txn_done | input | 1 | Transaction completion pulse |
| ev_ioc | input | 1 | Completed descriptor had interrupt-on-complete |
| ev_txn_err | input | 1 | Completed transaction ended in error |
| ev_short_pkt | input | 1 | Short packet received pulse |
| ev_mem_fail | input | 1 | Controller memory read returned a non-successful status |
| frnum_bit | input | 1 | Bit 13 of the microframe counter |
| port_chg | input | NPORT*NCHG | Change bits, NCHG per port, port p at [p*NCHG +: NCHG] |
| port_resume | input | NPORT | Force-resume bit per port |
| port_owner | input | NPORT | Port owner bit per port (1 = handed to companion) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Registered read data |
| irq | output | 1 | Interrupt request level |
| run_stop | output | 1 | Run/stop command bit |

## Verification
The assertions rely on the event inputs being single-cycle pulses and on the frame bit and port inputs holding their values through reset, so that no edge is seen out of the reset cycle. They also take the error flag as meaningful only together with the completion pulse. The stimulus drives every input on the falling edge, keeps all of them low or stable during reset, pulses events for exactly one cycle, and raises port and frame inputs once per scenario before reading the status back.

// File: rtl/usbsts_pkg.sv
package usbsts_pkg;
  localparam int STS_W     = 5;
  localparam int AW        = 2;
  localparam int B_USBINT  = 0;
  localparam int B_ERRINT  = 1;
  localparam int B_PCD     = 2;
  localparam int B_FLR     = 3;
  localparam int B_HSE     = 4;
  localparam int CMD_RS    = 0;

  typedef enum logic [AW-1:0] {
    RA_CMD  = 2'd0,
    RA_STS  = 2'd1,
    RA_IEN  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usbsts_port_chg.sv
module usbsts_port_chg #(
  parameter int NPORT = 4,
  parameter int NCHG  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORT*NCHG-1:0]  chg,
  input  logic [NPORT-1:0]       resume,
  input  logic [NPORT-1:0]       owner,
  output logic                   pcd_set
);
  localparam int CW = NPORT * NCHG;

  logic [CW-1:0]    chg_prev;
  logic [NPORT-1:0] res_prev;
  logic [NPORT-1:0] port_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_prev <= '0;
      res_prev <= '0;
    end else begin
      chg_prev <= chg;
      res_prev <= resume;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [NCHG-1:0] rise_bits;
    logic            res_rise;
    assign rise_bits    = chg[p*NCHG +: NCHG] & ~chg_prev[p*NCHG +: NCHG];
    assign res_rise     = resume[p] & ~res_prev[p];
    assign port_rise[p] = ~owner[p] & ((|rise_bits) | res_rise);
  end

  assign pcd_set = |port_rise;
endmodule

// File: rtl/usbsts_frame_roll.sv
module usbsts_frame_roll (
  input  logic clk,
  input  logic rst,
  input  logic frnum_bit,
  output logic flr_set
);
  logic bit_prev;

  always_ff @(posedge clk) begin
    if (rst) bit_prev <= 1'b0;
    else     bit_prev <= frnum_bit;
  end

  assign flr_set = frnum_bit ^ bit_prev;
endmodule

// File: rtl/usbsts_sticky.sv
module usbsts_sticky #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q,
  output logic [W-1:0] d
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign d[i] = set[i] | (q[i] & ~clr[i]);
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/usb_hc_status_intr.sv
module usb_hc_status_intr
  import usbsts_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int NCHG  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ev_txn_done,
  input  logic                  ev_ioc,
  input  logic                  ev_txn_err,
  input  logic                  ev_short_pkt,
  input  logic                  ev_mem_fail,
  input  logic                  frnum_bit,
  input  logic [NPORT*NCHG-1:0] port_chg,
  input  logic [NPORT-1:0]      port_resume,
  input  logic [NPORT-1:0]      port_owner,
  input  logic                  reg_wr,
  input  logic [AW-1:0]         reg_addr,
  input  logic [STS_W-1:0]      reg_wdata,
  output logic [STS_W-1:0]      reg_rdata,
  output logic                  irq,
  output logic                  run_stop
);
  logic             pcd_set;
  logic             flr_set;
  logic [STS_W-1:0] sts_set;
  logic [STS_W-1:0] sts_clr;
  logic [STS_W-1:0] sts_q;
  logic [STS_W-1:0] sts_d;
  logic [STS_W-1:0] ien_q;
  logic [STS_W-1:0] ien_d;
  logic             wr_sts;
  logic             wr_ien;
  logic             wr_cmd;

  usbsts_port_chg #(.NPORT(NPORT), .NCHG(NCHG)) i_port_chg (
    .clk    (clk),
    .rst    (rst),
    .chg    (port_chg),
    .resume (port_resume),
    .owner  (port_owner),
    .pcd_set(pcd_set)
  );

  usbsts_frame_roll i_frame_roll (
    .clk      (clk),
    .rst      (rst),
    .frnum_bit(frnum_bit),
    .flr_set  (flr_set)
  );

  assign wr_cmd = reg_wr && (reg_addr == RA_CMD);
  assign wr_sts = reg_wr && (reg_addr == RA_STS);
  assign wr_ien = reg_wr && (reg_addr == RA_IEN);

  always_comb begin
    sts_set           = '0;
    sts_set[B_USBINT] = (ev_txn_done && ev_ioc) || ev_short_pkt;
    sts_set[B_ERRINT] = ev_txn_done && ev_txn_err;
    sts_set[B_PCD]    = pcd_set;
    sts_set[B_FLR]    = flr_set;
    sts_set[B_HSE]    = ev_mem_fail;
  end

  assign sts_clr = wr_sts ? reg_wdata : '0;

  usbsts_sticky #(.W(STS_W)) i_sticky (
    .clk(clk),
    .rst(rst),
    .set(sts_set),
    .clr(sts_clr),
    .q  (sts_q),
    .d  (sts_d)
  );

  assign ien_d = wr_ien ? reg_wdata : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q    <= '0;
      irq      <= 1'b0;
      run_stop <= 1'b0;
    end else begin
      ien_q <= ien_d;
      irq   <= |(sts_d & ien_d);
      if (ev_mem_fail)  run_stop <= 1'b0;
      else if (wr_cmd)  run_stop <= reg_wdata[CMD_RS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr_e'(reg_addr))
        RA_CMD: begin
          reg_rdata         <= '0;
          reg_rdata[CMD_RS] <= run_stop;
        end
        RA_STS:  reg_rdata <= sts_q;
        RA_IEN:  reg_rdata <= ien_q;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/usbsts_checker.sv
module usbsts_checker
  import usbsts_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ev_txn_done,
  input logic             ev_ioc,
  input logic             ev_txn_err,
  input logic             ev_short_pkt,
  input logic             ev_mem_fail,
  input logic             frnum_bit,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [STS_W-1:0] reg_wdata,
  input logic             irq,
  input logic             run_stop,
  input logic [STS_W-1:0] sts_q,
  input logic [STS_W-1:0] ien_q
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (sts_q == '0 && ien_q == '0 && !irq && !run_stop)); // R1

  AST_USBINT_SET: assert property (@(posedge clk) disable iff (rst)
    ((ev_txn_done && ev_ioc) || ev_short_pkt) |=> sts_q[B_USBINT]); // R2

  AST_ERRINT_SET: assert property (@(posedge clk) disable iff (rst)
    (ev_txn_done && ev_txn_err) |=> sts_q[B_ERRINT]); // R3

  AST_HSE_HALTS: assert property (@(posedge clk) disable iff (rst)
    ev_mem_fail |=> (sts_q[B_HSE] && !run_stop)); // R4

  AST_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
    (frnum_bit != $past(frnum_bit)) |=> sts_q[B_FLR]); // R5

  AST_CLEAR_ONLY_BY_W1: assert property (@(posedge clk) disable iff (rst)
    (|($past(sts_q) & ~sts_q)) |-> ($past(reg_wr) && $past(reg_addr) == RA_STS)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (ev_short_pkt && reg_wr && reg_addr == RA_STS && reg_wdata[B_USBINT])
      |=> sts_q[B_USBINT]); // R8

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (|(sts_q & ien_q))); // R9

  AST_RS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_CMD && !ev_mem_fail)
      |=> (run_stop == $past(reg_wdata[CMD_RS]))); // R10
endmodule

bind usb_hc_status_intr usbsts_checker i_chk (
  .clk         (clk),
  .rst         (rst),
  .ev_txn_done (ev_txn_done),
  .ev_ioc      (ev_ioc),
  .ev_txn_err  (ev_txn_err),
  .ev_short_pkt(ev_short_pkt),
  .ev_mem_fail (ev_mem_fail),
  .frnum_bit   (frnum_bit),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .irq         (irq),
  .run_stop    (run_stop),
  .sts_q       (sts_q),
  .ien_q       (ien_q)
);

// File: tb/test_usb_hc_status_intr.sv
module test_usb_hc_status_intr;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 4;
  localparam int NCHG  = 3;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  ev_txn_done = 0, ev_ioc = 0, ev_txn_err = 0;
  logic                  ev_short_pkt = 0, ev_mem_fail = 0, frnum_bit = 0;
  logic [NPORT*NCHG-1:0] port_chg = '0;
  logic [NPORT-1:0]      port_resume = '0;
  logic [NPORT-1:0]      port_owner = '0;
  logic                  reg_wr = 0;
  logic [1:0]            reg_addr = '0;
  logic [4:0]            reg_wdata = '0;
  logic [4:0]            reg_rdata;
  logic                  irq;
  logic                  run_stop;

  int checks = 0;
  int errors = 0;
  logic arm = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0] addr;
    logic [4:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_hc_status_intr #(.NPORT(NPORT), .NCHG(NCHG)) i_usb_hc_status_intr (
    .clk(clk), .rst(rst),
    .ev_txn_done(ev_txn_done), .ev_ioc(ev_ioc), .ev_txn_err(ev_txn_err),
    .ev_short_pkt(ev_short_pkt), .ev_mem_fail(ev_mem_fail),
    .frnum_bit(frnum_bit), .port_chg(port_chg), .port_resume(port_resume),
    .port_owner(port_owner), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .run_stop(run_stop)
  );

  // Monitor: pops the expected read and compares it with the bus
  always @(negedge clk) begin
    if (arm) begin
      rd_item_t it;
      arm = 1'b0;
      it = sb_q.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: read addr %0d got %h expected %h", it.tag, it.addr, reg_rdata, it.exp);
      end
    end
  end

  // Every task starts and ends just after a falling edge
  task automatic rd(input logic [1:0] a, input logic [4:0] exp, input string tag);
    rd_item_t it;
    it.addr = a; it.exp = exp; it.tag = tag;
    reg_addr = a;
    sb_q.push_back(it);
    @(posedge clk);
    #1 arm = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic ev(input logic done, input logic ioc, input logic err,
                    input logic shrt, input logic fail);
    ev_txn_done = done; ev_ioc = ioc; ev_txn_err = err;
    ev_short_pkt = shrt; ev_mem_fail = fail;
    @(negedge clk);
    ev_txn_done = 0; ev_ioc = 0; ev_txn_err = 0; ev_short_pkt = 0; ev_mem_fail = 0;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    chk(run_stop, 1'b0, "R1 run_stop");
    rd(2'd0, 5'h00, "R1 cmd");
    rd(2'd1, 5'h00, "R1 sts");
    rd(2'd2, 5'h00, "R1 ien");
    // R10 software start
    wr(2'd0, 5'h1F);
    chk(run_stop, 1'b1, "R10 run_stop set");
    rd(2'd0, 5'h01, "R10 cmd read");
    // R2 completion with IOC, enable still off
    ev(1, 1, 0, 0, 0);
    rd(2'd1, 5'h01, "R2 ioc");
    chk(irq, 1'b0, "R9 masked");
    // completion without IOC sets nothing
    wr(2'd1, 5'h01);
    ev(1, 0, 0, 0, 0);
    rd(2'd1, 5'h00, "R2 no ioc");
    ev(1, 1, 0, 0, 0);
    // R9 enable all
    wr(2'd2, 5'h1F);
    chk(irq, 1'b1, "R9 enable raises irq");
    rd(2'd2, 5'h1F, "R11 ien read");
    // R7 clear by 1
    wr(2'd1, 5'h01);
    chk(irq, 1'b0, "R9 irq drops on clear");
    rd(2'd1, 5'h00, "R7 w1c");
    // R2 short packet, R7 write 0 no effect
    ev(0, 0, 0, 1, 0);
    chk(irq, 1'b1, "R9 irq on short");
    wr(2'd1, 5'h00);
    rd(2'd1, 5'h01, "R7 write 0 keeps");
    wr(2'd1, 5'h1E);
    rd(2'd1, 5'h01, "R7 other bits keep");
    wr(2'd1, 5'h01);
    // R3 error
    ev(1, 0, 1, 0, 0);
    rd(2'd1, 5'h02, "R3 err only");
    wr(2'd1, 5'h02);
    ev(1, 1, 1, 0, 0);
    rd(2'd1, 5'h03, "R3 err and ioc");
    wr(2'd1, 5'h03);
    rd(2'd1, 5'h00, "R7 both cleared");
    // R5 rollover both directions
    frnum_bit = 1'b1; @(negedge clk);
    rd(2'd1, 5'h08, "R5 rise");
    wr(2'd1, 5'h08);
    rd(2'd1, 5'h00, "R5 steady no set");
    frnum_bit = 1'b0; @(negedge clk);
    rd(2'd1, 5'h08, "R5 fall");
    wr(2'd1, 5'h08);
    // R6 port change
    port_owner[1] = 1'b1;
    port_chg[1*NCHG + 2] = 1'b1; @(negedge clk);
    rd(2'd1, 5'h00, "R6 owned port ignored");
    port_chg[2*NCHG + 0] = 1'b1; @(negedge clk);
    rd(2'd1, 5'h04, "R6 change rise");
    wr(2'd1, 5'h04);
    port_chg[2*NCHG + 0] = 1'b0; @(negedge clk);
    rd(2'd1, 5'h00, "R6 fall ignored");
    port_resume[0] = 1'b1; @(negedge clk);
    rd(2'd1, 5'h04, "R6 resume rise");
    wr(2'd1, 5'h04);
    port_resume[1] = 1'b1; @(negedge clk);
    rd(2'd1, 5'h00, "R6 owned resume ignored");
    // R8 set wins over clear
    ev(0, 0, 0, 1, 0);
    ev_short_pkt = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 5'h01;
    @(negedge clk);
    ev_short_pkt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd1, 5'h01, "R8 set wins");
    wr(2'd1, 5'h01);
    // R4 system error
    chk(run_stop, 1'b1, "R4 running before");
    ev(0, 0, 0, 0, 1);
    chk(run_stop, 1'b0, "R4 halted");
    rd(2'd1, 5'h10, "R4 hse");
    rd(2'd0, 5'h00, "R4 cmd cleared");
    wr(2'd1, 5'h10);
    wr(2'd0, 5'h01);
    ev_mem_fail = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 5'h01;
    @(negedge clk);
    ev_mem_fail = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk(run_stop, 1'b0, "R4 beats software set");
    rd(2'd1, 5'h10, "R4 hse again");
    // R9 masking: only port change enabled
    wr(2'd2, 5'h04);
    chk(irq, 1'b0, "R9 hse masked");
    wr(2'd2, 5'h10);
    chk(irq, 1'b1, "R9 hse enabled");
    wr(2'd1, 5'h10);
    chk(irq, 1'b0, "R9 cleared");
    // R10 software stop
    wr(2'd0, 5'h01);
    wr(2'd0, 5'h00);
    chk(run_stop, 1'b0, "R10 stop");
    // R11 unmapped address
    rd(2'd3, 5'h00, "R11 unmapped");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    finish_run();
  end
endmodule